// File: doc/BRIEF.md
# Vectored Interrupt Entry and Return Sequencer

This block carries a processor through the steps of taking a maskable vectored interrupt and coming back from it. An interrupt grant arrives with a priority level and a vector index. The sequencer then saves the current status word and program counter to a stack through a synchronous memory port, one word per cycle. It drops the global interrupt enable bit in the status word and records the granted level in an in-service register. It reads the handler address from a vector table port and makes it the new program counter.

A separate return command undoes the entry. It reads the saved words back in the opposite order and restores the program counter and then the status word. It also retires the most urgent level still marked in service. Between sequences, the core can overwrite the program counter and status word through an update strobe, which models normal execution. Choosing among competing requests is left to an arbiter outside this block; that arbiter can use the `ie` output.

Top module: `irq_entry_seq`

## Requirements
- R1: After a grant is accepted, three stack writes happen in three consecutive cycles, each first decrementing the stack pointer. They are the status word at SP-1, then PC bits 19:16 zero-extended to 16 bits at SP-2, then PC bits 15:0 at SP-3. The stack pointer ends 3 lower.
- R2: Entry clears the interrupt enable bit (status word bit IE_BIT, default 5) and leaves every other status bit as it was.
- R3: Entry sets in-service bit N, where N is the granted level; other in-service bits keep their values.
- R4: The vector table is read at address = vector index in the cycle of the third write. Its data, returned one cycle later, becomes the PC.
- R5: A return reads the stack at SP (PC bits 15:0), then SP+1 (PC bits 19:16), then SP+2 (status word), incrementing SP after each read. It restores PC and then the status word, and the stack pointer ends 3 higher.
- R6: A return clears only the set in-service bit with the lowest index; level 0 is the most urgent.
- R7: `busy` is high for exactly 4 cycles for an entry and 4 cycles for a return, starting the cycle after the command is taken. The stack port is never read and written in the same cycle.
- R8: A grant or return command that arrives while `busy` is high is ignored. It causes no extra stack write and no change to PC, status word or in-service bits.
- R9: If a grant and a return command arrive together while idle, the grant is taken and the return is dropped.
- R10: `core_upd` loads PC and status word from `core_pc` and `core_psw` only when idle and no command is taken in that cycle. Otherwise it has no effect.
- R11: After reset, PC is RST_PC (default 0), the status word is 0, SP is SP_INIT (default 0x0100), in-service bits are 0 and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grant_valid | input | 1 | Maskable interrupt grant |
| grant_level | input | 2 | Priority level of the grant |
| grant_vector | input | 5 | Vector table index of the grant |
| reti_req | input | 1 | Return-from-interrupt command |
| core_upd | input | 1 | Core update strobe for PC and status word |
| core_pc | input | 20 | PC value written by the core |
| core_psw | input | 16 | Status word value written by the core |
| stk_we | output | 1 | Stack write enable |
| stk_re | output | 1 | Stack read enable (data next cycle) |
| stk_addr | output | 16 | Stack word address |
| stk_wdata | output | 16 | Stack write data |
| stk_rdata | input | 16 | Stack read data |
| vec_re | output | 1 | Vector table read enable (data next cycle) |
| vec_addr | output | 5 | Vector table index |
| vec_rdata | input | 20 | Handler address from the vector table |
| pc | output | 20 | Program counter |
| psw | output | 16 | Status word |
| ie | output | 1 | Global interrupt enable (status word bit IE_BIT) |
| sp | output | 16 | Stack pointer |
| isr | output | 4 | In-service bits, one per level |
| busy | output | 1 | Sequence in progress |

## Verification
The bench builds the block with its default parameters. A 20-bit PC over 16-bit stack words means the upper PC word holds only a nibble, so zero extension on push and truncation on pop are both exercised. Four levels let three nested entries leave a non-contiguous in-service pattern, so the return order follows priority and not arrival order. A 5-bit vector index reaches the top table slot (31). A stack pointer starting at 0x0100 lets nested frames cross below an 8-bit boundary.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_PUSH_PSW = 4'd1,
        ST_PUSH_PCH = 4'd2,
        ST_PUSH_PCL = 4'd3,
        ST_VEC_LOAD = 4'd4,
        ST_POP_PCL  = 4'd5,
        ST_POP_PCH  = 4'd6,
        ST_POP_PSW  = 4'd7,
        ST_RET_DONE = 4'd8
    } seq_state_e;

    localparam int ENTRY_CYCLES  = 4;
    localparam int RETURN_CYCLES = 4;

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] pick
);
    logic seen;

    always_comb begin
        pick = '0;
        seen = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !seen) begin
                pick[i] = 1'b1;
            end
            seen = seen | req[i];
        end
    end
endmodule

// File: rtl/irq_isr_bank.sv
module irq_isr_bank #(
    parameter int LEVELS = 4,
    parameter int LVL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [LVL_W-1:0]  set_lvl,
    input  logic              clr_en,
    output logic [LEVELS-1:0] isr
);
    logic [LEVELS-1:0] isr_d, isr_q;
    logic [LEVELS-1:0] set_oh;
    logic [LEVELS-1:0] retire_oh;

    for (genvar g = 0; g < LEVELS; g++) begin : g_set_dec
        assign set_oh[g] = (set_lvl == LVL_W'(g));
    end

    irq_prio_pick #(.N(LEVELS)) u_pick (
        .req  (isr_q),
        .pick (retire_oh)
    );

    always_comb begin
        isr_d = isr_q;
        if (clr_en) begin
            isr_d = isr_d & ~retire_oh;
        end
        if (set_en) begin
            isr_d = isr_d | set_oh;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= '0;
        end else begin
            isr_q <= isr_d;
        end
    end

    assign isr = isr_q;
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int               PC_W    = 20,
    parameter int               PSW_W   = 16,
    parameter int               WORD_W  = 16,
    parameter int               SP_W    = 16,
    parameter int               LEVELS  = 4,
    parameter int               VEC_W   = 5,
    parameter int               IE_BIT  = 5,
    parameter logic [SP_W-1:0]  SP_INIT = 16'h0100,
    parameter logic [PC_W-1:0]  RST_PC  = '0,
    localparam int              LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant_valid,
    input  logic [LVL_W-1:0]  grant_level,
    input  logic [VEC_W-1:0]  grant_vector,
    input  logic              reti_req,
    input  logic              core_upd,
    input  logic [PC_W-1:0]   core_pc,
    input  logic [PSW_W-1:0]  core_psw,
    output logic              stk_we,
    output logic              stk_re,
    output logic [SP_W-1:0]   stk_addr,
    output logic [WORD_W-1:0] stk_wdata,
    input  logic [WORD_W-1:0] stk_rdata,
    output logic              vec_re,
    output logic [VEC_W-1:0]  vec_addr,
    input  logic [PC_W-1:0]   vec_rdata,
    output logic [PC_W-1:0]   pc,
    output logic [PSW_W-1:0]  psw,
    output logic              ie,
    output logic [SP_W-1:0]   sp,
    output logic [LEVELS-1:0] isr,
    output logic              busy
);
    localparam int PCH_W = PC_W - WORD_W;

    typedef struct packed {
        seq_state_e         st;
        logic [PC_W-1:0]    pc;
        logic [PSW_W-1:0]   psw;
        logic [SP_W-1:0]    sp;
        logic [LVL_W-1:0]   lvl;
        logic [VEC_W-1:0]   vec;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      isr_set, isr_clr;
    logic [SP_W-1:0] sp_dec;
    logic [SP_W-1:0] sp_inc;

    assign sp_dec = r_q.sp - SP_W'(1);
    assign sp_inc = r_q.sp + SP_W'(1);

    always_comb begin
        r_d       = r_q;
        stk_we    = 1'b0;
        stk_re    = 1'b0;
        stk_addr  = r_q.sp;
        stk_wdata = '0;
        vec_re    = 1'b0;
        vec_addr  = r_q.vec;
        isr_set   = 1'b0;
        isr_clr   = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (grant_valid) begin
                    r_d.st  = ST_PUSH_PSW;
                    r_d.lvl = grant_level;
                    r_d.vec = grant_vector;
                end else if (reti_req) begin
                    r_d.st = ST_POP_PCL;
                end else if (core_upd) begin
                    r_d.pc  = core_pc;
                    r_d.psw = core_psw;
                end
            end
            ST_PUSH_PSW: begin
                stk_we    = 1'b1;
                stk_addr  = sp_dec;
                stk_wdata = WORD_W'(r_q.psw);
                r_d.sp    = sp_dec;
                r_d.st    = ST_PUSH_PCH;
            end
            ST_PUSH_PCH: begin
                stk_we    = 1'b1;
                stk_addr  = sp_dec;
                stk_wdata = WORD_W'(r_q.pc[PC_W-1:WORD_W]);
                r_d.sp    = sp_dec;
                r_d.st    = ST_PUSH_PCL;
            end
            ST_PUSH_PCL: begin
                stk_we          = 1'b1;
                stk_addr        = sp_dec;
                stk_wdata       = r_q.pc[WORD_W-1:0];
                r_d.sp          = sp_dec;
                vec_re          = 1'b1;
                r_d.psw[IE_BIT] = 1'b0;
                isr_set         = 1'b1;
                r_d.st          = ST_VEC_LOAD;
            end
            ST_VEC_LOAD: begin
                r_d.pc = vec_rdata;
                r_d.st = ST_IDLE;
            end
            ST_POP_PCL: begin
                stk_re = 1'b1;
                r_d.sp = sp_inc;
                r_d.st = ST_POP_PCH;
            end
            ST_POP_PCH: begin
                stk_re                 = 1'b1;
                r_d.sp                 = sp_inc;
                r_d.pc[WORD_W-1:0]     = stk_rdata;
                r_d.st                 = ST_POP_PSW;
            end
            ST_POP_PSW: begin
                stk_re                 = 1'b1;
                r_d.sp                 = sp_inc;
                r_d.pc[PC_W-1:WORD_W]  = stk_rdata[PCH_W-1:0];
                r_d.st                 = ST_RET_DONE;
            end
            ST_RET_DONE: begin
                r_d.psw = PSW_W'(stk_rdata);
                isr_clr = 1'b1;
                r_d.st  = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.pc  <= RST_PC;
            r_q.psw <= '0;
            r_q.sp  <= SP_INIT;
            r_q.lvl <= '0;
            r_q.vec <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    irq_isr_bank #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_isr (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (isr_set),
        .set_lvl (r_q.lvl),
        .clr_en  (isr_clr),
        .isr     (isr)
    );

    assign pc   = r_q.pc;
    assign psw  = r_q.psw;
    assign ie   = r_q.psw[IE_BIT];
    assign sp   = r_q.sp;
    assign busy = (r_q.st != ST_IDLE);
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
    parameter int PC_W   = 20,
    parameter int PSW_W  = 16,
    parameter int WORD_W = 16,
    parameter int SP_W   = 16,
    parameter int LEVELS = 4,
    parameter int IE_BIT = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              stk_we,
    input logic              stk_re,
    input logic [SP_W-1:0]   stk_addr,
    input logic [WORD_W-1:0] stk_wdata,
    input logic              vec_re,
    input logic [PC_W-1:0]   pc,
    input logic [PSW_W-1:0]  psw,
    input logic [SP_W-1:0]   sp,
    input logic [LEVELS-1:0] isr
);
    AST_PSW_PUSHED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && stk_we) |-> (stk_wdata == WORD_W'(psw) && stk_addr == sp - SP_W'(1))); // R1
    AST_SP_DEC_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        stk_we |=> (sp == $past(sp) - SP_W'(1))); // R1
    AST_IE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        vec_re |=> !psw[IE_BIT]); // R2
    AST_ISR_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        vec_re |=> (isr != '0)); // R3
    AST_SP_INC_ON_POP: assert property (@(posedge clk) disable iff (!rst_n)
        stk_re |=> (sp == $past(sp) + SP_W'(1))); // R5
    AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_we && stk_re)); // R7
    AST_IDLE_NO_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!stk_we && !stk_re)); // R8
    AST_PC_HELD_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && stk_we) |-> $stable(pc)); // R10
endmodule

bind irq_entry_seq irq_entry_seq_chk #(
    .PC_W   (PC_W),
    .PSW_W  (PSW_W),
    .WORD_W (WORD_W),
    .SP_W   (SP_W),
    .LEVELS (LEVELS),
    .IE_BIT (IE_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .stk_we    (stk_we),
    .stk_re    (stk_re),
    .stk_addr  (stk_addr),
    .stk_wdata (stk_wdata),
    .vec_re    (vec_re),
    .pc        (pc),
    .psw       (psw),
    .sp        (sp),
    .isr       (isr)
);

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        grant_valid = 1'b0;
    logic [1:0]  grant_level = '0;
    logic [4:0]  grant_vector = '0;
    logic        reti_req = 1'b0;
    logic        core_upd = 1'b0;
    logic [19:0] core_pc = '0;
    logic [15:0] core_psw = '0;
    logic        stk_we, stk_re, vec_re, ie, busy;
    logic [15:0] stk_addr, stk_wdata, sp, psw;
    logic [15:0] stk_rdata = '0;
    logic [4:0]  vec_addr;
    logic [19:0] vec_rdata = '0;
    logic [19:0] pc;
    logic [3:0]  isr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [15:0] smem [0:255];
    logic [31:0] wq[$];
    logic [35:0] frames[$];
    logic [19:0] m_pc  = '0;
    logic [15:0] m_psw = '0;
    logic [15:0] m_sp  = 16'h0100;
    logic [3:0]  m_isr = '0;

    always #4 clk = ~clk;

    irq_entry_seq dut (
        .clk(clk), .rst_n(rst_n),
        .grant_valid(grant_valid), .grant_level(grant_level), .grant_vector(grant_vector),
        .reti_req(reti_req), .core_upd(core_upd), .core_pc(core_pc), .core_psw(core_psw),
        .stk_we(stk_we), .stk_re(stk_re), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
        .stk_rdata(stk_rdata), .vec_re(vec_re), .vec_addr(vec_addr), .vec_rdata(vec_rdata),
        .pc(pc), .psw(psw), .ie(ie), .sp(sp), .isr(isr), .busy(busy)
    );

    function automatic logic [19:0] vtab(input logic [4:0] i);
        return 20'(32'h50000 + 32'(i) * 32'h1357);
    endfunction

    always @(posedge clk) begin
        if (stk_we) smem[stk_addr[7:0]] <= stk_wdata;
        if (stk_re) stk_rdata <= smem[stk_addr[7:0]];
        if (vec_re) vec_rdata <= vtab(vec_addr);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: every stack write must match the next expected item (R1, R8)
    always @(negedge clk) begin
        if (rst_n && stk_we) begin
            if (wq.size() == 0) begin
                chk(1'b0, "R8", "unexpected stack write addr/data", {stk_addr, stk_wdata}, 32'h0);
            end else begin
                logic [31:0] e;
                e = wq.pop_front();
                chk({stk_addr, stk_wdata} == e, "R1", "stack write addr/data", {stk_addr, stk_wdata}, e);
            end
        end
    end

    task automatic core_set(input logic [19:0] npc, input logic [15:0] npsw);
        @(negedge clk);
        core_upd = 1'b1; core_pc = npc; core_psw = npsw;
        m_pc = npc; m_psw = npsw;
        @(negedge clk);
        core_upd = 1'b0;
        chk(pc == m_pc, "R10", "pc after core update", 32'(pc), 32'(m_pc));
        chk(psw == m_psw, "R10", "psw after core update", 32'(psw), 32'(m_psw));
    endtask

    task automatic do_grant(input logic [1:0] lvl, input logic [4:0] vec,
                            input bit with_reti, input bit pester);
        int cnt;
        @(negedge clk);
        grant_valid = 1'b1; grant_level = lvl; grant_vector = vec; reti_req = with_reti;
        wq.push_back({m_sp - 16'd1, m_psw});
        wq.push_back({m_sp - 16'd2, 12'h000, m_pc[19:16]});
        wq.push_back({m_sp - 16'd3, m_pc[15:0]});
        frames.push_back({m_pc, m_psw});
        m_sp = m_sp - 16'd3;
        m_psw[5] = 1'b0;
        m_isr[lvl] = 1'b1;
        m_pc = vtab(vec);
        @(negedge clk);
        if (pester) begin
            grant_level = lvl ^ 2'b10; grant_vector = vec ^ 5'h01; reti_req = 1'b1;
            core_upd = 1'b1; core_pc = 20'hFFFFF; core_psw = 16'hFFFF;
        end else begin
            grant_valid = 1'b0; reti_req = 1'b0;
        end
        cnt = 0;
        while (busy) begin
            cnt++;
            @(negedge clk);
        end
        grant_valid = 1'b0; reti_req = 1'b0; core_upd = 1'b0;
        chk(cnt == 4, "R7", "entry busy cycles", 32'(cnt), 32'd4);
        chk(pc == m_pc, "R4", "pc loaded from vector table", 32'(pc), 32'(m_pc));
        chk(psw == m_psw && !ie, "R2", "psw with ie cleared", 32'(psw), 32'(m_psw));
        chk(isr == m_isr, "R3", "in-service bits after entry", 32'(isr), 32'(m_isr));
        chk(sp == m_sp, "R1", "sp after entry", 32'(sp), 32'(m_sp));
        chk(wq.size() == 0, "R1", "pending stack writes", 32'(wq.size()), 32'd0);
        if (with_reti) begin
            chk(isr == m_isr && sp == m_sp, "R9", "return dropped when grant wins", 32'(sp), 32'(m_sp));
        end
        if (pester) begin
            chk(isr == m_isr && pc == m_pc, "R8", "commands during busy ignored", 32'(isr), 32'(m_isr));
            chk(psw == m_psw, "R10", "core update during busy ignored", 32'(psw), 32'(m_psw));
        end
    endtask

    task automatic do_reti();
        int cnt;
        logic [35:0] f;
        @(negedge clk);
        reti_req = 1'b1;
        f = frames.pop_back();
        m_pc = f[35:16];
        m_psw = f[15:0];
        m_sp = m_sp + 16'd3;
        for (int i = 0; i < 4; i++) begin
            if (m_isr[i]) begin
                m_isr[i] = 1'b0;
                break;
            end
        end
        @(negedge clk);
        reti_req = 1'b0;
        cnt = 0;
        while (busy) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == 4, "R7", "return busy cycles", 32'(cnt), 32'd4);
        chk(pc == m_pc, "R5", "pc restored", 32'(pc), 32'(m_pc));
        chk(psw == m_psw, "R5", "psw restored", 32'(psw), 32'(m_psw));
        chk(sp == m_sp, "R5", "sp after return", 32'(sp), 32'(m_sp));
        chk(isr == m_isr, "R6", "most urgent in-service bit retired", 32'(isr), 32'(m_isr));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(pc == 20'h0, "R11", "reset pc", 32'(pc), 32'h0);
        chk(psw == 16'h0, "R11", "reset psw", 32'(psw), 32'h0);
        chk(sp == 16'h0100, "R11", "reset sp", 32'(sp), 32'h0100);
        chk(isr == 4'h0, "R11", "reset isr", 32'(isr), 32'h0);
        chk(!busy, "R11", "reset busy", 32'(busy), 32'h0);

        core_set(20'h12345, 16'h00A5);
        do_grant(2'd2, 5'd3, 1'b0, 1'b0);
        core_set(20'hABCDE, 16'h8063);
        do_grant(2'd0, 5'd7, 1'b1, 1'b0);
        do_grant(2'd3, 5'd31, 1'b0, 1'b1);
        do_reti();
        do_reti();
        do_reti();
        chk(wq.size() == 0, "R8", "no stray stack writes", 32'(wq.size()), 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R7 watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule